// File: doc/BRIEF.md
# PCI Indirect Initiator Access Unit

This unit lets a processor on a local 32-bit register bus issue single PCI transactions one at a time. Software loads a target address, a command with active-low byte enables, and optionally write data into a small set of registers. A read starts when the command register receives a read command. A write starts when the write-data register is written while a write command is held. The PCI side is a simple target handshake: the unit raises a request and holds it until the target reports completion or a master abort. Read data is captured into a read-data register. An abort sets a sticky status bit that software clears by writing one to it.

A combinational encoder sits beside the register path. It turns a bus, slot, function and byte offset into a configuration address. It also gives the active-low byte enables for a 1, 2 or 4 byte access and moves a write value onto its byte lanes. Combinations that are not allowed are flagged, and software then issues no transaction.

Top module: `pci_ind_unit`

## Requirements
- R1: The unit has five local registers: address at offset 0x00 (32 bits), command/byte-enable at 0x04 (bits 7:0, upper bits read 0), write data at 0x08, read data at 0x0C, and status at 0x20 with the abort flag in bit 1. Any other offset reads 0. All registers are 0 after reset.
- R2: Writing offset 0x04 with a read command in bits 3:0 (I/O read 0x2, memory read 0x6, configuration read 0xA) starts a transaction. From the next cycle `pci_req_o` is high, `pci_cmd_o` equals bits 3:0, `pci_be_n_o` equals bits 7:4 and `pci_addr_o` equals the address register.
- R3: Writing offset 0x08 while the held command is a write (I/O write 0x3, memory write 0x7, configuration write 0xB) starts a transaction with `pci_wdata_o` equal to the written value. Writing 0x04 with a non-read code, or 0x08 while a non-write code is held, only stores the value.
- R4: On `pci_done_i` during a read, `pci_rdata_i` is captured and can be read at offset 0x0C from the next cycle. A completed write leaves the read-data register unchanged.
- R5: `busy_o` and `pci_req_o` are high from the cycle after a start until the cycle after completion or abort. While the request is high, the address, command, byte enables and write data stay stable.
- R6: While busy, a local write is held off (`lb_ready_o` low) and changes no register. Reads are always ready.
- R7: `pci_abort_i` while busy ends the transaction and sets status bit 1. An aborted read loads 0xFFFFFFFF into the read-data register. `pci_done_i` or `pci_abort_i` while idle has no effect.
- R8: Writing status offset 0x20 with bit 1 set clears the abort flag. Writing it with bit 1 clear leaves the flag unchanged.
- R9: Encoder lane n is `enc_where_i[1:0]`. With `enc_size_i` = 1, `enc_be_n_o` is 0xF with only bit n cleared. With size 2 and n in 0..2, bits n and n+1 are cleared. With size 4 and n = 0, the result is 0x0.
- R10: The encoder sets `enc_illegal_o`, forces `enc_be_n_o` to 0xF and forces `enc_addr_o` to 0 in these cases: size 2 at lane 3, size 4 at a lane other than 0, a size other than 1, 2 or 4, or bus 0 with slot 0 or slot above 21.
- R11: For bus 0, `enc_addr_o` has one device-select bit set at position 32 - slot, the function in bits 10:8, the offset bits 7:2 in bits 7:2, bits 1:0 equal to 00, and all other bits 0.
- R12: For a bus other than 0, `enc_addr_o` has bits 31:24 at 0, the bus in 23:16, the slot in 15:11, the function in 10:8, the offset bits 7:2 in 7:2, bit 1 at 0 and bit 0 at 1.
- R13: `enc_wdata_o` equals `enc_value_i` shifted left by 8 × lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lb_req_i | input | 1 | Local bus access request |
| lb_we_i | input | 1 | Local bus write (1) or read (0) |
| lb_addr_i | input | AW | Local register offset |
| lb_wdata_i | input | 32 | Local write data |
| lb_rdata_o | output | 32 | Local read data (combinational) |
| lb_ready_o | output | 1 | Access accepted this cycle |
| busy_o | output | 1 | Transaction outstanding |
| pci_req_o | output | 1 | PCI transaction request |
| pci_cmd_o | output | 4 | PCI command code |
| pci_be_n_o | output | 4 | PCI byte enables, active low |
| pci_addr_o | output | 32 | PCI address |
| pci_wdata_o | output | 32 | PCI write data |
| pci_rdata_i | input | 32 | PCI read data, valid with done |
| pci_done_i | input | 1 | Target completion pulse |
| pci_abort_i | input | 1 | Master abort pulse |
| enc_bus_i | input | 8 | Encoder bus number |
| enc_slot_i | input | 5 | Encoder slot number |
| enc_func_i | input | 3 | Encoder function number |
| enc_where_i | input | 8 | Encoder configuration byte offset |
| enc_size_i | input | 3 | Encoder access size in bytes |
| enc_value_i | input | 32 | Encoder write value |
| enc_addr_o | output | 32 | Encoded configuration address |
| enc_be_n_o | output | 4 | Encoded byte enables, active low |
| enc_wdata_o | output | 32 | Lane-aligned write value |
| enc_illegal_o | output | 1 | Illegal lane, size or slot |

## Verification
The assertions assume that the target pulses `pci_done_i` or `pci_abort_i` only while a request is outstanding. They also assume that the encoder inputs never carry unknown values once reset is released. The bench drives all encoder inputs to defined values from time zero and raises target responses only after it has seen `pci_req_o` high. In one deliberate step it pulses done while idle, to show that the pulse is ignored. Local accesses are applied at the falling edge and held until the unit reports ready, so no access depends on edge ordering.

// File: rtl/pci_ind_pkg.sv
package pci_ind_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  localparam int OFS_ADDR = 'h00;
  localparam int OFS_CBE  = 'h04;
  localparam int OFS_WDAT = 'h08;
  localparam int OFS_RDAT = 'h0C;
  localparam int OFS_STAT = 'h20;
  localparam int STAT_ABORT_BIT = 1;

  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'h2,
    CMD_IO_WR  = 4'h3,
    CMD_MEM_RD = 4'h6,
    CMD_MEM_WR = 4'h7,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } pci_cmd_e;

  function automatic logic is_rd_cmd(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_MEM_RD) || (c == CMD_CFG_RD);
  endfunction

  function automatic logic is_wr_cmd(input logic [3:0] c);
    return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_CFG_WR);
  endfunction
endpackage

// File: rtl/pci_ind_cfg_enc.sv
module pci_ind_cfg_enc
  import pci_ind_pkg::*;
#(
  parameter int MAX_SLOT = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    bus_i,
  input  logic [4:0]    slot_i,
  input  logic [2:0]    func_i,
  input  logic [7:0]    where_i,
  input  logic [2:0]    size_i,
  input  logic [DW-1:0] value_i,
  output logic [31:0]   addr_o,
  output logic [LANES-1:0] be_n_o,
  output logic [DW-1:0] wdata_o,
  output logic          illegal_o
);
  localparam logic [4:0] SLOT_LIM = 5'(MAX_SLOT);

  logic [1:0]       lane;
  logic             lane_ok, slot_ok;
  logic [LANES-1:0] mask;
  logic [31:0]      near_addr, far_addr, sel_bit;

  assign lane = where_i[1:0];

  always_comb begin
    lane_ok = 1'b0;
    mask    = '0;
    case (size_i)
      3'd1: begin lane_ok = 1'b1;         mask = 4'b0001 << lane; end
      3'd2: begin lane_ok = (lane != 2'd3); mask = 4'b0011 << lane; end
      3'd4: begin lane_ok = (lane == 2'd0); mask = 4'b1111;         end
      default: ;
    endcase
  end

  assign slot_ok   = (bus_i != 8'd0) || ((slot_i != 5'd0) && (slot_i <= SLOT_LIM));
  assign illegal_o = !(lane_ok && slot_ok);

  // device select: one bit at position 32 - slot
  assign sel_bit   = 32'h1 << (6'd32 - {1'b0, slot_i});
  assign near_addr = {21'd0, func_i, where_i[7:2], 2'b00} | sel_bit;
  assign far_addr  = {8'd0, bus_i, slot_i, func_i, where_i[7:2], 2'b01};

  assign addr_o  = illegal_o ? 32'd0 : ((bus_i == 8'd0) ? near_addr : far_addr);
  assign be_n_o  = illegal_o ? 4'hF : ~mask;
  assign wdata_o = value_i << {lane, 3'b000};

  a_r9_byte_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && size_i == 3'd1) |-> ($countones(~be_n_o) == 1));
  a_r9_half_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && size_i == 3'd2) |-> ($countones(~be_n_o) == 2));
  a_r11_near_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && bus_i == 8'd0) |-> ($onehot(addr_o[31:11]) && addr_o[1:0] == 2'b00));
  a_r12_far_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && bus_i != 8'd0) |-> (addr_o[0] && !addr_o[1] && !addr_o[31]));
endmodule

// File: rtl/pci_ind_regs.sv
module pci_ind_regs
  import pci_ind_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lb_req_i,
  input  logic          lb_we_i,
  input  logic [AW-1:0] lb_addr_i,
  input  logic [DW-1:0] lb_wdata_i,
  output logic [DW-1:0] lb_rdata_o,
  output logic          lb_ready_o,
  input  logic          busy_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          abort_evt_i,
  output logic [31:0]   addr_o,
  output logic [7:0]    cbe_o,
  output logic [DW-1:0] wdata_o,
  output logic          start_o,
  output logic          start_rd_o
);
  logic [31:0]   addr_q;
  logic [7:0]    cbe_q;
  logic [DW-1:0] wdata_q;
  logic          stat_q;
  logic          wr_acc;
  logic          sel_addr, sel_cbe, sel_wdat, sel_rdat, sel_stat;

  assign sel_addr = (lb_addr_i == AW'(OFS_ADDR));
  assign sel_cbe  = (lb_addr_i == AW'(OFS_CBE));
  assign sel_wdat = (lb_addr_i == AW'(OFS_WDAT));
  assign sel_rdat = (lb_addr_i == AW'(OFS_RDAT));
  assign sel_stat = (lb_addr_i == AW'(OFS_STAT));

  assign lb_ready_o = !busy_i || !lb_we_i;
  assign wr_acc     = lb_req_i && lb_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cbe_q   <= '0;
      wdata_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (wr_acc && sel_addr) addr_q  <= lb_wdata_i;
      if (wr_acc && sel_cbe)  cbe_q   <= lb_wdata_i[7:0];
      if (wr_acc && sel_wdat) wdata_q <= lb_wdata_i;
      if (abort_evt_i)                                   stat_q <= 1'b1;
      else if (wr_acc && sel_stat && lb_wdata_i[STAT_ABORT_BIT]) stat_q <= 1'b0;
    end
  end

  // read launches on command write, write launches on data write
  assign start_o = wr_acc && ((sel_cbe && is_rd_cmd(lb_wdata_i[3:0])) ||
                              (sel_wdat && is_wr_cmd(cbe_q[3:0])));
  assign start_rd_o = sel_cbe;

  always_comb begin
    lb_rdata_o = '0;
    if (lb_req_i && !lb_we_i) begin
      if (sel_addr) lb_rdata_o = addr_q;
      if (sel_cbe)  lb_rdata_o = {{(DW-8){1'b0}}, cbe_q};
      if (sel_wdat) lb_rdata_o = wdata_q;
      if (sel_rdat) lb_rdata_o = rdata_i;
      if (sel_stat) lb_rdata_o[STAT_ABORT_BIT] = stat_q;
    end
  end

  assign addr_o  = addr_q;
  assign cbe_o   = cbe_q;
  assign wdata_o = wdata_q;

  a_r6_frozen_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(addr_q) && $stable(cbe_q) && $stable(wdata_q)));
  a_r7_abort_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_evt_i |=> stat_q);
  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && sel_stat && lb_wdata_i[STAT_ABORT_BIT] && !abort_evt_i) |=> !stat_q);
  a_r2_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
endmodule

// File: rtl/pci_ind_xfer.sv
module pci_ind_xfer
  import pci_ind_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_rd_i,
  input  logic          pci_done_i,
  input  logic          pci_abort_i,
  input  logic [DW-1:0] pci_rdata_i,
  output logic          busy_o,
  output logic          abort_evt_o,
  output logic [DW-1:0] rdata_o
);
  logic          busy_q, rd_q;
  logic [DW-1:0] rdata_q;

  assign abort_evt_o = busy_q && pci_abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= start_rd_i;
      end else if (busy_q && (pci_done_i || pci_abort_i)) begin
        busy_q <= 1'b0;
      end
      // abort wins over done; aborted read returns all ones
      if (busy_q && rd_q && pci_abort_i)     rdata_q <= '1;
      else if (busy_q && rd_q && pci_done_i) rdata_q <= pci_rdata_i;
    end
  end

  assign busy_o  = busy_q;
  assign rdata_o = rdata_q;

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !pci_done_i && !pci_abort_i) |=> busy_q);
  a_r5_req_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (pci_done_i || pci_abort_i)) |=> !busy_q);
  a_r7_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> (!busy_q && $stable(rdata_q)));
endmodule

// File: rtl/pci_ind_unit.sv
module pci_ind_unit
  import pci_ind_pkg::*;
#(
  parameter int AW       = 8,
  parameter int MAX_SLOT = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lb_req_i,
  input  logic          lb_we_i,
  input  logic [AW-1:0] lb_addr_i,
  input  logic [31:0]   lb_wdata_i,
  output logic [31:0]   lb_rdata_o,
  output logic          lb_ready_o,
  output logic          busy_o,
  output logic          pci_req_o,
  output logic [3:0]    pci_cmd_o,
  output logic [3:0]    pci_be_n_o,
  output logic [31:0]   pci_addr_o,
  output logic [31:0]   pci_wdata_o,
  input  logic [31:0]   pci_rdata_i,
  input  logic          pci_done_i,
  input  logic          pci_abort_i,
  input  logic [7:0]    enc_bus_i,
  input  logic [4:0]    enc_slot_i,
  input  logic [2:0]    enc_func_i,
  input  logic [7:0]    enc_where_i,
  input  logic [2:0]    enc_size_i,
  input  logic [31:0]   enc_value_i,
  output logic [31:0]   enc_addr_o,
  output logic [3:0]    enc_be_n_o,
  output logic [31:0]   enc_wdata_o,
  output logic          enc_illegal_o
);
  logic          busy, start, start_rd, abort_evt;
  logic [DW-1:0] rdata_cap, wdata_q;
  logic [31:0]   addr_q;
  logic [7:0]    cbe_q;

  pci_ind_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .lb_req_i, .lb_we_i, .lb_addr_i, .lb_wdata_i, .lb_rdata_o, .lb_ready_o,
    .busy_i(busy), .rdata_i(rdata_cap), .abort_evt_i(abort_evt),
    .addr_o(addr_q), .cbe_o(cbe_q), .wdata_o(wdata_q),
    .start_o(start), .start_rd_o(start_rd)
  );

  pci_ind_xfer u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .start_rd_i(start_rd),
    .pci_done_i, .pci_abort_i, .pci_rdata_i,
    .busy_o(busy), .abort_evt_o(abort_evt), .rdata_o(rdata_cap)
  );

  pci_ind_cfg_enc #(.MAX_SLOT(MAX_SLOT)) u_enc (
    .clk_i, .rst_ni,
    .bus_i(enc_bus_i), .slot_i(enc_slot_i), .func_i(enc_func_i),
    .where_i(enc_where_i), .size_i(enc_size_i), .value_i(enc_value_i),
    .addr_o(enc_addr_o), .be_n_o(enc_be_n_o), .wdata_o(enc_wdata_o),
    .illegal_o(enc_illegal_o)
  );

  assign busy_o      = busy;
  assign pci_req_o   = busy;
  assign pci_cmd_o   = cbe_q[3:0];
  assign pci_be_n_o  = cbe_q[7:4];
  assign pci_addr_o  = addr_q;
  assign pci_wdata_o = wdata_q;

  a_r5_pci_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_o && !pci_done_i && !pci_abort_i) |=>
      ($stable(pci_addr_o) && $stable(pci_cmd_o) && $stable(pci_be_n_o) && $stable(pci_wdata_o)));
  a_r6_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && lb_req_i && lb_we_i) |-> !lb_ready_o);
endmodule

// File: tb/pci_ind_unit_tb.sv
`timescale 1ns/1ps
module pci_ind_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lb_req = 1'b0, lb_we = 1'b0;
  logic [7:0]  lb_addr = '0;
  logic [31:0] lb_wdata = '0, lb_rdata;
  logic        lb_ready, busy, pci_req;
  logic [3:0]  pci_cmd, pci_be_n;
  logic [31:0] pci_addr, pci_wdata, pci_rdata = '0;
  logic        pci_done = 1'b0, pci_abort = 1'b0;
  logic [7:0]  enc_bus = '0;
  logic [4:0]  enc_slot = 5'd1;
  logic [2:0]  enc_func = '0;
  logic [7:0]  enc_where = '0;
  logic [2:0]  enc_size = 3'd4;
  logic [31:0] enc_value = '0;
  logic [31:0] enc_addr, enc_wdata;
  logic [3:0]  enc_be_n;
  logic        enc_illegal;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pci_ind_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lb_req_i(lb_req), .lb_we_i(lb_we), .lb_addr_i(lb_addr), .lb_wdata_i(lb_wdata),
    .lb_rdata_o(lb_rdata), .lb_ready_o(lb_ready), .busy_o(busy),
    .pci_req_o(pci_req), .pci_cmd_o(pci_cmd), .pci_be_n_o(pci_be_n),
    .pci_addr_o(pci_addr), .pci_wdata_o(pci_wdata), .pci_rdata_i(pci_rdata),
    .pci_done_i(pci_done), .pci_abort_i(pci_abort),
    .enc_bus_i(enc_bus), .enc_slot_i(enc_slot), .enc_func_i(enc_func),
    .enc_where_i(enc_where), .enc_size_i(enc_size), .enc_value_i(enc_value),
    .enc_addr_o(enc_addr), .enc_be_n_o(enc_be_n), .enc_wdata_o(enc_wdata),
    .enc_illegal_o(enc_illegal)
  );

  // {bus, slot, func, where, size, illegal, be_n, addr}
  localparam int NVEC = 11;
  localparam logic [63:0] ENC_VEC [NVEC] = '{
    {8'h00, 5'd1,  3'd0, 8'h00, 3'd4, 1'b0, 4'h0, 32'h8000_0000},
    {8'h00, 5'd21, 3'd3, 8'h10, 3'd1, 1'b0, 4'hE, 32'h0000_0B10},
    {8'h00, 5'd5,  3'd1, 8'h3E, 3'd2, 1'b0, 4'h3, 32'h0800_013C},
    {8'h00, 5'd0,  3'd0, 8'h00, 3'd4, 1'b1, 4'hF, 32'h0000_0000},
    {8'h00, 5'd22, 3'd0, 8'h00, 3'd1, 1'b1, 4'hF, 32'h0000_0000},
    {8'h02, 5'd3,  3'd5, 8'h47, 3'd1, 1'b0, 4'h7, 32'h0002_1D45},
    {8'hFF, 5'd31, 3'd7, 8'hFF, 3'd2, 1'b1, 4'hF, 32'h0000_0000},
    {8'h01, 5'd0,  3'd0, 8'h06, 3'd4, 1'b1, 4'hF, 32'h0000_0000},
    {8'h01, 5'd31, 3'd7, 8'hFD, 3'd1, 1'b0, 4'hD, 32'h0001_FFFD},
    {8'h00, 5'd2,  3'd0, 8'h01, 3'd2, 1'b0, 4'h9, 32'h4000_0000},
    {8'h04, 5'd1,  3'd0, 8'h00, 3'd3, 1'b1, 4'hF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    lb_req = 1'b1; lb_we = 1'b1; lb_addr = a; lb_wdata = d;
    #1;
    while (!lb_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    lb_req = 1'b0; lb_we = 1'b0;
  endtask

  task automatic lb_read(input logic [7:0] a, output logic [31:0] d);
    lb_req = 1'b1; lb_we = 1'b0; lb_addr = a;
    #0.5;
    d = lb_rdata;
    lb_req = 1'b0;
  endtask

  task automatic target_pulse(input logic is_abort, input logic [31:0] d);
    @(negedge clk);
    pci_done = !is_abort; pci_abort = is_abort; pci_rdata = d;
    @(negedge clk);
    pci_done = 1'b0; pci_abort = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    lb_read(8'h00, rd); chk("R1 reset addr", rd, 32'h0);
    lb_read(8'h04, rd); chk("R1 reset cbe", rd, 32'h0);
    lb_read(8'h0C, rd); chk("R1 reset rdata", rd, 32'h0);
    lb_read(8'h20, rd); chk("R1 reset status", rd, 32'h0);
    chk("R5 reset busy", {31'd0, busy}, 32'd0);

    // encoder table: R9 R10 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {enc_bus, enc_slot, enc_func, enc_where, enc_size} = ENC_VEC[i][63:37];
      #1;
      chk($sformatf("R9 R10 R11 R12 vec%0d addr", i), enc_addr, ENC_VEC[i][31:0]);
      chk($sformatf("R9 R10 vec%0d be_n", i), {28'd0, enc_be_n}, {28'd0, ENC_VEC[i][35:32]});
      chk($sformatf("R10 vec%0d illegal", i), {31'd0, enc_illegal}, {31'd0, ENC_VEC[i][36]});
    end

    // R13 lane placement
    @(negedge clk);
    enc_bus = 8'h01; enc_size = 3'd1; enc_where = 8'h02; enc_value = 32'h0000_00AB;
    #1; chk("R13 lane2", enc_wdata, 32'h00AB_0000);
    enc_where = 8'h03; enc_value = 32'h0000_00C5;
    #1; chk("R13 lane3", enc_wdata, 32'hC500_0000);

    // R1 address register, R2 read launch
    lb_write(8'h00, 32'h1234_5678);
    lb_read(8'h00, rd); chk("R1 addr readback", rd, 32'h1234_5678);
    lb_write(8'h04, 32'h0000_00E6);
    chk("R2 req", {31'd0, pci_req}, 32'd1);
    chk("R2 cmd", {28'd0, pci_cmd}, 32'h6);
    chk("R2 be_n", {28'd0, pci_be_n}, 32'hE);
    chk("R2 addr", pci_addr, 32'h1234_5678);
    chk("R5 busy", {31'd0, busy}, 32'd1);
    // R6 hold-off of writes, reads still served
    lb_req = 1'b1; lb_we = 1'b1; lb_addr = 8'h00; lb_wdata = 32'hDEAD_BEEF;
    #0.5; chk("R6 write held", {31'd0, lb_ready}, 32'd0);
    lb_we = 1'b0;
    #0.5; chk("R6 read ready", {31'd0, lb_ready}, 32'd1);
    lb_we = 1'b1;
    @(negedge clk);
    chk("R5 addr stable", pci_addr, 32'h1234_5678);
    lb_req = 1'b0; lb_we = 1'b0;
    target_pulse(1'b0, 32'hCAFE_F00D);
    chk("R5 req dropped", {31'd0, pci_req}, 32'd0);
    lb_read(8'h0C, rd); chk("R4 read data", rd, 32'hCAFE_F00D);
    lb_read(8'h00, rd); chk("R6 held write no effect", rd, 32'h1234_5678);

    // R3 write launch
    lb_write(8'h04, 32'h0000_0007);
    chk("R3 write cmd no launch", {31'd0, pci_req}, 32'd0);
    lb_write(8'h08, 32'h0000_55AA);
    chk("R3 write launch", {31'd0, pci_req}, 32'd1);
    chk("R3 write data", pci_wdata, 32'h0000_55AA);
    chk("R3 write cmd", {28'd0, pci_cmd}, 32'h7);
    target_pulse(1'b0, 32'h0BAD_0BAD);
    lb_read(8'h0C, rd); chk("R4 write leaves rdata", rd, 32'hCAFE_F00D);

    // R3 reserved code only stores
    lb_write(8'h04, 32'h0000_0001);
    chk("R3 reserved no launch", {31'd0, pci_req}, 32'd0);
    lb_write(8'h08, 32'h0000_1111);
    chk("R3 data with non-write cmd", {31'd0, pci_req}, 32'd0);
    lb_read(8'h08, rd); chk("R1 wdata readback", rd, 32'h0000_1111);

    // R7 abort on read
    lb_write(8'h04, 32'h0000_000A);
    chk("R2 cfg read launch", {31'd0, pci_req}, 32'd1);
    target_pulse(1'b1, 32'h0);
    chk("R7 abort ends", {31'd0, busy}, 32'd0);
    lb_read(8'h20, rd); chk("R7 abort flag", rd, 32'h0000_0002);
    lb_read(8'h0C, rd); chk("R7 abort rdata", rd, 32'hFFFF_FFFF);

    // R7 done while idle ignored
    target_pulse(1'b0, 32'h0000_1234);
    chk("R7 idle done busy", {31'd0, busy}, 32'd0);
    lb_read(8'h0C, rd); chk("R7 idle done rdata", rd, 32'hFFFF_FFFF);

    // R8 write-one-to-clear
    lb_write(8'h20, 32'h0000_0000);
    lb_read(8'h20, rd); chk("R8 zero write keeps", rd, 32'h0000_0002);
    lb_write(8'h20, 32'h0000_0002);
    lb_read(8'h20, rd); chk("R8 one write clears", rd, 32'h0);

    // R1 other offsets
    lb_read(8'h10, rd); chk("R1 unmapped", rd, 32'h0);
    lb_read(8'h04, rd); chk("R1 cbe readback", rd, 32'h0000_000A);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule